// File: doc/BRIEF.md
# Looping Two-Track Bitstream Pattern Store

This block holds two one-bit patterns of up to `DEPTH` entries each and replays them without end while a run input is held high. One track carries a stimulus bitstream that an external coarse analog filter smooths into a test waveform. The other track carries a sigma-delta style bitstream whose running average sets a DC reference level. Because both streams come from precomputed one-bit patterns, no multi-bit converter is needed. The patterns are worked out off-chip and written in unchanged; the block never encodes or alters them.

A host fills the two tracks through a write port while run is low. It may also program a loop length between 1 and `DEPTH`. When run rises, one shared read index walks from entry 0 up to length-1 and wraps. Both tracks are therefore always presented from the same entry, and the output repeats with a period of exactly the loop length. A one-cycle marker flags every cycle that presents entry 0, so test capture can be aligned to the pattern period. Dropping run forces all outputs to zero and rewinds the index.

Top module: `loop_pattern_store`

## Requirements
- R1: After reset, `stim_bit`, `ref_bit` and `period_start` are 0, and the loop length is `DEPTH`.
- R2: On every clock edge at which `run` is sampled low, all three outputs become 0 at that edge.
- R3: The k-th consecutive edge (k = 0, 1, 2, …) at which `run` is sampled high presents entry (k mod L) of the stimulus track on `stim_bit`, where L is the loop length. The bit is passed through as stored, with no change.
- R4: `ref_bit` at each run edge comes from the same entry index as `stim_bit`, so the two tracks stay aligned.
- R5: `period_start` is 1 exactly on the run edges that present entry 0, and 0 on all others.
- R6: An edge with `load_we`=1 and `run`=0 stores `load_stim` and `load_ref` at `load_addr` (entry index, 0 to `DEPTH`-1). Writes made while `run`=1 are ignored and leave both tracks unchanged.
- R7: An edge with `len_we`=1 and `run`=0 sets the loop length to `len_value`. A value of 0 is taken as 1, and a value above `DEPTH` is taken as `DEPTH`. A length write made while `run`=1 is ignored.
- R8: After any edge with `run` low, the next run edge presents entry 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to replay patterns, low to idle and load |
| load_we | input | 1 | Pattern write enable (idle only) |
| load_addr | input | $clog2(DEPTH) | Entry index to write |
| load_stim | input | 1 | Bit written to the stimulus track |
| load_ref | input | 1 | Bit written to the reference track |
| len_we | input | 1 | Loop length write enable (idle only) |
| len_value | input | $clog2(DEPTH+1) | Requested loop length |
| stim_bit | output | 1 | Stimulus bitstream toward the analog filter |
| ref_bit | output | 1 | Sigma-delta bitstream setting the DC level |
| period_start | output | 1 | High on cycles presenting entry 0 |

## Verification
Every output is registered. The result of a given edge's inputs therefore shows up right after that edge and is stable until the next one. Writes to the tracks or to the length take effect at the edge that samples them, so they govern the first run edge that follows. The bench stamps each expected item with the cycle count of the edge that must produce it, and compares in the falling half of that cycle. A reference model of the tracks, length and entry index, kept apart from the design, supplies the expected bits. Writes attempted during run are caught later, when the same entries are replayed with their original contents.

// File: rtl/lps_pkg.sv
package lps_pkg;

  // One entry of the two aligned tracks.
  typedef struct packed {
    logic stim;
    logic lvl;
  } track_pair_t;

  localparam int unsigned TRACK_STIM = 0;
  localparam int unsigned TRACK_LVL  = 1;
  localparam int unsigned NUM_TRACKS = 2;

  // Map a requested loop length onto the legal range 1..depth.
  function automatic int unsigned clamp_len(int unsigned req, int unsigned depth);
    if (req == 0)     return 1;
    if (req > depth)  return depth;
    return req;
  endfunction

  // Entry index that follows cur for a loop of the given length.
  function automatic int unsigned next_index(int unsigned cur, int unsigned len);
    if (cur + 1 >= len) return 0;
    return cur + 1;
  endfunction

endpackage

// File: rtl/lps_track_mem.sv
// One-bit-wide track storage, DEPTH entries, one write port, one read port.
module lps_track_mem #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic             wdata,
  input  logic [AW-1:0]    raddr,
  output logic             rdata,
  output logic [DEPTH-1:0] bits_o
);

  logic [DEPTH-1:0] bits_q;
  logic             addr_ok;

  assign addr_ok = (32'(waddr) < 32'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (we && addr_ok) begin
      bits_q[waddr] <= wdata;
    end
  end

  assign rdata  = bits_q[raddr];
  assign bits_o = bits_q;

endmodule

// File: rtl/lps_len_reg.sv
// Loop length register, clamped into 1..DEPTH on write.
module lps_len_reg
  import lps_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [LW-1:0] value,
  output logic [LW-1:0] len_o
);

  logic [LW-1:0] len_q;
  logic [LW-1:0] len_legal;

  assign len_legal = LW'(clamp_len(32'(value), 32'(DEPTH)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LW'(DEPTH);
    end else if (we) begin
      len_q <= len_legal;
    end
  end

  assign len_o = len_q;

endmodule

// File: rtl/lps_read_ptr.sv
// Shared wrapping read index for both tracks.
module lps_read_ptr
  import lps_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] ptr_o,
  output logic          at_start_o,
  output logic          wrap_o
);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_next;

  assign ptr_next   = AW'(next_index(32'(ptr_q), 32'(len)));
  assign at_start_o = (ptr_q == '0);
  assign wrap_o     = run && (ptr_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (!run) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_next;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/lps_out_stage.sv
// Output register: presents the read entry and the period marker while
// running, holds everything at zero while idle.
module lps_out_stage
  import lps_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  track_pair_t pair_in,
  input  logic        at_start,
  output logic        stim_o,
  output logic        lvl_o,
  output logic        mark_o
);

  track_pair_t pair_q;
  logic        mark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      mark_q <= 1'b0;
    end else if (run) begin
      pair_q <= pair_in;
      mark_q <= at_start;
    end else begin
      pair_q <= '0;
      mark_q <= 1'b0;
    end
  end

  assign stim_o = pair_q.stim;
  assign lvl_o  = pair_q.lvl;
  assign mark_o = mark_q;

endmodule

// File: rtl/loop_pattern_store.sv
// Two aligned one-bit pattern tracks replayed in a loop of programmable length.
module loop_pattern_store
  import lps_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic          load_stim,
  input  logic          load_ref,
  input  logic          len_we,
  input  logic [LW-1:0] len_value,
  output logic          stim_bit,
  output logic          ref_bit,
  output logic          period_start
);

  // Named internal events, visible to the bound checker.
  logic          wr_accept;
  logic          len_accept;
  logic          wrap_evt;
  logic          at_start;
  logic [AW-1:0] rd_ptr;
  logic [LW-1:0] loop_len;

  logic [NUM_TRACKS-1:0] trk_wdata;
  logic [NUM_TRACKS-1:0] trk_rdata;
  logic [DEPTH-1:0]      trk_bits [NUM_TRACKS];
  logic [DEPTH-1:0]      stim_bits;
  logic [DEPTH-1:0]      lvl_bits;
  track_pair_t           rd_pair;

  assign wr_accept  = load_we && !run;
  assign len_accept = len_we && !run;

  assign trk_wdata[TRACK_STIM] = load_stim;
  assign trk_wdata[TRACK_LVL]  = load_ref;

  for (genvar t = 0; t < NUM_TRACKS; t++) begin : g_track
    lps_track_mem #(
      .DEPTH (DEPTH),
      .AW    (AW)
    ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_accept),
      .waddr  (load_addr),
      .wdata  (trk_wdata[t]),
      .raddr  (rd_ptr),
      .rdata  (trk_rdata[t]),
      .bits_o (trk_bits[t])
    );
  end

  assign stim_bits    = trk_bits[TRACK_STIM];
  assign lvl_bits     = trk_bits[TRACK_LVL];
  assign rd_pair.stim = trk_rdata[TRACK_STIM];
  assign rd_pair.lvl  = trk_rdata[TRACK_LVL];

  lps_len_reg #(
    .DEPTH (DEPTH),
    .LW    (LW)
  ) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (len_accept),
    .value (len_value),
    .len_o (loop_len)
  );

  lps_read_ptr #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .LW    (LW)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .len        (loop_len),
    .ptr_o      (rd_ptr),
    .at_start_o (at_start),
    .wrap_o     (wrap_evt)
  );

  lps_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .pair_in  (rd_pair),
    .at_start (at_start),
    .stim_o   (stim_bit),
    .lvl_o    (ref_bit),
    .mark_o   (period_start)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             stim_bit,
  input logic             ref_bit,
  input logic             period_start,
  input logic [AW-1:0]    rd_ptr,
  input logic [LW-1:0]    loop_len,
  input logic [DEPTH-1:0] stim_bits,
  input logic [DEPTH-1:0] lvl_bits
);

  AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!stim_bit && !ref_bit && !period_start)); // R2

  AST_PTR_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    LW'(rd_ptr) < loop_len); // R3

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && LW'(rd_ptr) == loop_len - LW'(1)) |=> (rd_ptr == '0)); // R3

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && LW'(rd_ptr) != loop_len - LW'(1)) |=> (rd_ptr == $past(rd_ptr) + AW'(1))); // R3

  AST_STIM_FROM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (stim_bit == $past(stim_bits[rd_ptr]))); // R3

  AST_REF_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (ref_bit == $past(lvl_bits[rd_ptr]))); // R4

  AST_MARK_AT_ENTRY0: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_ptr == '0) |=> period_start); // R5

  AST_NO_MARK_ELSEWHERE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rd_ptr != '0) |=> !period_start); // R5

  AST_TRACKS_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(stim_bits) && $stable(lvl_bits))); // R6

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_len >= LW'(1)) && (loop_len <= LW'(DEPTH))); // R7

  AST_LEN_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(loop_len)); // R7

  AST_IDLE_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (rd_ptr == '0)); // R8

endmodule

bind loop_pattern_store lps_checker #(
  .DEPTH (DEPTH),
  .AW    (AW),
  .LW    (LW)
) u_lps_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run          (run),
  .stim_bit     (stim_bit),
  .ref_bit      (ref_bit),
  .period_start (period_start),
  .rd_ptr       (rd_ptr),
  .loop_len     (loop_len),
  .stim_bits    (stim_bits),
  .lvl_bits     (lvl_bits)
);

// File: tb/loop_pattern_store_bench.sv
module loop_pattern_store_bench;

  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          load_we = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic          load_stim = 1'b0;
  logic          load_ref = 1'b0;
  logic          len_we = 1'b0;
  logic [LW-1:0] len_value = '0;
  logic          stim_bit;
  logic          ref_bit;
  logic          period_start;

  loop_pattern_store #(.DEPTH(DEPTH)) u_loop_pattern_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (run),
    .load_we      (load_we),
    .load_addr    (load_addr),
    .load_stim    (load_stim),
    .load_ref     (load_ref),
    .len_we       (len_we),
    .len_value    (len_value),
    .stim_bit     (stim_bit),
    .ref_bit      (ref_bit),
    .period_start (period_start)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct {
    int    due;
    bit    s;
    bit    r;
    bit    p;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  // Reference state, built from the requirements.
  bit m_stim [DEPTH];
  bit m_ref  [DEPTH];
  int m_len = DEPTH;
  int m_idx = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare items whose due cycle has arrived.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (stim_bit !== e.s || ref_bit !== e.r || period_start !== e.p) begin
        errors++;
        $display("FAIL %s cyc %0d: got stim=%0b ref=%0b mark=%0b exp stim=%0b ref=%0b mark=%0b",
                 e.tag, cyc, stim_bit, ref_bit, period_start, e.s, e.r, e.p);
      end
    end
  end

  function automatic int clamp(int v);
    if (v == 0) return 1;
    if (v > DEPTH) return DEPTH;
    return v;
  endfunction

  // Driver: apply one cycle of inputs and push the expected result.
  task automatic tick(bit rn, bit we, int addr, bit s, bit r, bit lwe, int lv, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    run       = rn;
    load_we   = we;
    load_addr = AW'(addr);
    load_stim = s;
    load_ref  = r;
    len_we    = lwe;
    len_value = LW'(lv);
    e.due = cyc + 1;
    e.tag = tag;
    if (rn) begin
      e.s = m_stim[m_idx];
      e.r = m_ref[m_idx];
      e.p = (m_idx == 0);
      m_idx = (m_idx + 1 >= m_len) ? 0 : m_idx + 1;
    end else begin
      e.s = 0; e.r = 0; e.p = 0;
      m_idx = 0;
      if (we) begin m_stim[addr] = s; m_ref[addr] = r; end
      if (lwe) m_len = clamp(lv);
    end
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang exp finish");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_stim[i] = 0; m_ref[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 reset state
    if (stim_bit !== 0 || ref_bit !== 0 || period_start !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %0b%0b%0b exp 000", stim_bit, ref_bit, period_start);
    end

    // Load full patterns while idle; outputs stay zero (R2, R6).
    for (int a = 0; a < DEPTH; a++)
      tick(0, 1, a, bit'(a[0] ^ a[3]), bit'(a % 3 == 0), 0, 0, "R2 R6 load");

    // Default length DEPTH from reset (R1), looping and alignment (R3 R4 R5).
    for (int k = 0; k < 2 * DEPTH + 5; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R1 R3 R4 R5 loop");

    // Writes and a length write while running are ignored (R6, R7).
    for (int k = 0; k < 10; k++)
      tick(1, 1, k, 1, 1, 1, 3, "R6 R7 run writes");

    // Idle then shorter loop; replay must show original contents (R8, R6, R7).
    tick(0, 0, 0, 0, 0, 0, 0, "R2 idle");
    tick(0, 0, 0, 0, 0, 1, 5, "R7 set len 5");
    for (int k = 0; k < 17; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R8 R6 R7 len5");

    // Length write during run ignored: still period 5 (R7).
    for (int k = 0; k < 12; k++)
      tick(1, 0, 0, 0, 0, 1, 2, "R7 len frozen");

    // Length 0 is taken as 1: entry 0 and marker every cycle (R7, R5).
    tick(0, 0, 0, 0, 0, 1, 0, "R7 len0");
    for (int k = 0; k < 4; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R7 R5 len1");

    // Length above DEPTH is taken as DEPTH (R7).
    tick(0, 0, 0, 0, 0, 1, DEPTH + 30, "R7 len big");
    for (int k = 0; k < DEPTH + 6; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R7 len clamp");

    // Idle rewrite of entry 2, short loop, restart after idle (R6, R8).
    tick(0, 1, 2, 1, 0, 0, 0, "R6 rewrite");
    tick(0, 1, 0, 0, 1, 1, 4, "R6 rewrite0");
    for (int k = 0; k < 9; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R6 R8 replay");
    tick(0, 0, 0, 0, 0, 0, 0, "R2 stop");
    for (int k = 0; k < 3; k++)
      tick(1, 0, 0, 0, 0, 0, 0, "R8 restart");
    tick(0, 0, 0, 0, 0, 0, 0, "R2 end");

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending exp 0", q.size());
    end
    done = 1;
    finish_run();
  end

endmodule